// File: doc/BRIEF.md
# Fast GPIO Port Register Block

This block holds the direction and output-set state for up to five 32-bit general-purpose I/O ports. Each port gets its own register bank on a simple synchronous bus. A direction bit of 1 makes the matching pin an output. The output latch can only be raised, one bit at a time, through the set register. A set only takes effect on a pin that is an output and is not handed to a secondary function.

The direction register can be written as a full word, as either of two half-words, or as any of its four bytes. Every narrow view lands on the same 32-bit register, and a narrow write changes only the lanes it addresses. The bus data is lane-aligned: the byte at address offset k always travels on write-data bits 8k+7..8k, and the byte enable for that lane is bit k. Reads are combinational on the address and always return the whole 32-bit word of the addressed register.

On the pin side, each port drives an output-value vector (the latch) and an output-enable vector. It also takes a per-pin mask that marks pins owned by a secondary function.

Top module: `gfp_top`

## Requirements
- R1: After reset every direction bit, every latch bit, every output-enable bit and every output bit is 0. Reads of the direction and set registers return 0.
- R2: Port p's bank starts at address 0x20*p. Within the bank the direction register is at word offset 0x00 and the set register at 0x18. A read returns the addressed register's full 32-bit value in the cycle after any write to it has been clocked in.
- R3: A byte access (size code 0) at bank offset 0x00+k writes only direction bits 8k..8k+7, taken from write-data bits 8k+7..8k. All other direction bits keep their values.
- R4: A half-word access (size code 1) at offset 0x00 covers pins 0..15, and at offset 0x02 it covers pins 16..31. A half-word access at an odd address, or a word access (size code 2) whose two low address bits are not 00, is ignored.
- R5: A word access with all byte enables set replaces all 32 direction bits.
- R6: Within the lanes that the size and address select, only lanes whose byte enable is 1 are written. Size code 3 writes nothing.
- R7: A write to the set register raises latch bit n when, before the write, data bit n is 1, direction bit n is 1 and function-mask bit n is 0. Every other latch bit keeps its value, so writing 0 never lowers a bit.
- R8: A read of the set register returns the latch value. The latch value appears unchanged on the port's output-value vector.
- R9: Output-enable bit n equals direction bit n AND NOT function-mask bit n.
- R10: Accesses to a bank index of NUM_PORTS or more, or to any word offset other than 0x00 and 0x18, change no state, and reads from them return 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe, sampled on the clock edge |
| bus_addr | input | ADDR_W | Byte address |
| bus_size | input | 2 | Access size: 0 byte, 1 half-word, 2 word, 3 reserved |
| bus_be | input | 4 | Byte-lane enables, bit k for write-data bits 8k+7..8k |
| bus_wdata | input | 32 | Lane-aligned write data |
| bus_rdata | output | 32 | Word value of the addressed register, 0 when unmapped |
| pin_func | input | NUM_PORTS*32 | Per-pin secondary-function mask, port p at bits 32p+31..32p |
| pin_out | output | NUM_PORTS*32 | Output latch value per pin |
| pin_oe | output | NUM_PORTS*32 | Output enable per pin |

## Verification
Some properties are checked on every clock cycle. The latch never loses a bit, and it gains a bit only where the pin was an enabled output. Output-enable never asserts on a function-owned pin or an input pin. Direction bits outside the written lanes are never disturbed, and no state moves without a decoded hit. Unmapped reads stay at zero, and each write selects at most one register. Only the bench's scenarios can show the remaining behaviours. These are the correct lane placement for each byte and half-word alias, the refusal of misaligned and reserved-size accesses, the independence of the five banks, and readback values agreeing with a model driven through mixed random accesses.

// File: rtl/gfp_pkg.sv
package gfp_pkg;
  localparam int unsigned PORT_W = 32;
  localparam int unsigned LANES  = PORT_W / 8;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_RSVD = 2'd3
  } acc_size_e;

  typedef enum logic [1:0] {
    SEL_NONE = 2'd0,
    SEL_DIR  = 2'd1,
    SEL_SET  = 2'd2
  } reg_sel_e;

  // Lanes touched by an access of the given size at the given low address bits.
  function automatic logic [LANES-1:0] size_lanes(input logic [1:0] low,
                                                  input logic [1:0] size);
    logic [LANES-1:0] m;
    m = '0;
    case (size)
      SZ_BYTE: m = LANES'(1) << low;
      SZ_HALF: m = low[0] ? '0 : (low[1] ? 4'b1100 : 4'b0011);
      SZ_WORD: m = (low == 2'b00) ? '1 : '0;
      default: m = '0;
    endcase
    return m;
  endfunction

  // Expand a lane mask to a bit mask.
  function automatic logic [PORT_W-1:0] lane_bits(input logic [LANES-1:0] lanes);
    logic [PORT_W-1:0] b;
    for (int k = 0; k < LANES; k++) b[8*k +: 8] = {8{lanes[k]}};
    return b;
  endfunction

  // Set-only latch update, filtered by pin ownership.
  function automatic logic [PORT_W-1:0] set_merge(input logic [PORT_W-1:0] latch,
                                                  input logic [PORT_W-1:0] data,
                                                  input logic [PORT_W-1:0] mask,
                                                  input logic [PORT_W-1:0] dir,
                                                  input logic [PORT_W-1:0] func);
    return latch | (data & mask & dir & ~func);
  endfunction
endpackage

// File: rtl/gfp_decode.sv
module gfp_decode
  import gfp_pkg::*;
#(
  parameter int unsigned NUM_PORTS = 5,
  parameter int unsigned ADDR_W    = 8,
  parameter int unsigned BANK_LSB  = 5,
  parameter int unsigned DIR_WOFS  = 0,
  parameter int unsigned SET_WOFS  = 6
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 bus_wr,
  input  logic [ADDR_W-1:0]    bus_addr,
  input  logic [1:0]           bus_size,
  input  logic [LANES-1:0]     bus_be,
  output logic [NUM_PORTS-1:0] dir_wr,
  output logic [NUM_PORTS-1:0] set_wr,
  output logic [PORT_W-1:0]    wr_mask,
  output logic [NUM_PORTS-1:0] rd_bank,
  output reg_sel_e             rd_sel
);
  localparam int unsigned BANK_W = ADDR_W - BANK_LSB;
  localparam int unsigned WOFS_W = BANK_LSB - 2;

  logic [BANK_W-1:0] bank;
  logic [WOFS_W-1:0] wofs;
  logic [LANES-1:0]  lanes;
  logic              lanes_any;

  assign bank      = bus_addr[ADDR_W-1:BANK_LSB];
  assign wofs      = bus_addr[BANK_LSB-1:2];
  assign lanes     = size_lanes(bus_addr[1:0], bus_size) & bus_be;
  assign lanes_any = |lanes;
  assign wr_mask   = lane_bits(lanes);

  always_comb begin
    if (wofs == WOFS_W'(DIR_WOFS))      rd_sel = SEL_DIR;
    else if (wofs == WOFS_W'(SET_WOFS)) rd_sel = SEL_SET;
    else                                rd_sel = SEL_NONE;
  end

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_bank
    assign rd_bank[p] = (bank == BANK_W'(p));
    assign dir_wr[p]  = bus_wr && lanes_any && rd_bank[p] && (rd_sel == SEL_DIR);
    assign set_wr[p]  = bus_wr && lanes_any && rd_bank[p] && (rd_sel == SEL_SET);
  end

  // R10: one write reaches at most one register of one bank
  assert_single_target_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({dir_wr, set_wr}));
  // R3: a byte access never spans more than one lane
  assert_byte_one_lane_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_size == SZ_BYTE) |-> ($countones(wr_mask) <= 8));
  // R6: reserved size never produces a write
  assert_rsvd_no_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_size == SZ_RSVD) |-> (dir_wr == '0 && set_wr == '0));
endmodule

// File: rtl/gfp_port.sv
module gfp_port
  import gfp_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              dir_wr,
  input  logic              set_wr,
  input  logic [PORT_W-1:0] wr_mask,
  input  logic [PORT_W-1:0] wdata,
  input  logic [PORT_W-1:0] func,
  output logic [PORT_W-1:0] dir_q,
  output logic [PORT_W-1:0] latch_q,
  output logic [PORT_W-1:0] oe
);
  logic [PORT_W-1:0] dir_nxt;
  logic [PORT_W-1:0] latch_nxt;

  assign dir_nxt   = (dir_q & ~wr_mask) | (wdata & wr_mask);
  assign latch_nxt = set_merge(latch_q, wdata, wr_mask, dir_q, func);
  assign oe        = dir_q & ~func;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q   <= '0;
      latch_q <= '0;
    end else begin
      if (dir_wr) dir_q   <= dir_nxt;
      if (set_wr) latch_q <= latch_nxt;
    end
  end

  // R7: latch bits never fall
  assert_latch_no_fall_R7: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((latch_q & $past(latch_q)) == $past(latch_q)));
  // R7: a latch bit only rises on an owned output pin
  assert_latch_rise_filtered_R7: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((latch_q & ~$past(latch_q) & ~($past(dir_q) & ~$past(func))) == '0));
  // R9: output enable stays off for inputs and function-owned pins
  assert_oe_owned_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ((oe & func) == '0) && ((oe & ~dir_q) == '0));
  // R3: lanes outside the write mask keep their direction bits
  assert_dir_lanes_kept_R3: assert property (@(posedge clk) disable iff (!rst_n)
    dir_wr |=> (((dir_q ^ $past(dir_q)) & ~$past(wr_mask)) == '0));
  // R10: no decoded hit, no direction change
  assert_dir_idle_stable_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !dir_wr |=> $stable(dir_q));
endmodule

// File: rtl/gfp_top.sv
module gfp_top
  import gfp_pkg::*;
#(
  parameter int unsigned NUM_PORTS = 5,
  parameter int unsigned ADDR_W    = 8
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        bus_wr,
  input  logic [ADDR_W-1:0]           bus_addr,
  input  logic [1:0]                  bus_size,
  input  logic [3:0]                  bus_be,
  input  logic [31:0]                 bus_wdata,
  output logic [31:0]                 bus_rdata,
  input  logic [NUM_PORTS*32-1:0]     pin_func,
  output logic [NUM_PORTS*32-1:0]     pin_out,
  output logic [NUM_PORTS*32-1:0]     pin_oe
);
  localparam int unsigned BANK_LSB = 5;
  localparam int unsigned DIR_WOFS = 0;
  localparam int unsigned SET_WOFS = 6;

  logic [NUM_PORTS-1:0] dir_wr;
  logic [NUM_PORTS-1:0] set_wr;
  logic [NUM_PORTS-1:0] rd_bank;
  logic [PORT_W-1:0]    wr_mask;
  reg_sel_e             rd_sel;
  logic [PORT_W-1:0]    dir_all   [NUM_PORTS];
  logic [PORT_W-1:0]    latch_all [NUM_PORTS];
  logic                 rd_mapped;

  gfp_decode #(
    .NUM_PORTS(NUM_PORTS), .ADDR_W(ADDR_W), .BANK_LSB(BANK_LSB),
    .DIR_WOFS(DIR_WOFS), .SET_WOFS(SET_WOFS)
  ) i_decode (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_size(bus_size), .bus_be(bus_be), .dir_wr(dir_wr), .set_wr(set_wr),
    .wr_mask(wr_mask), .rd_bank(rd_bank), .rd_sel(rd_sel)
  );

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    logic [PORT_W-1:0] oe_p;
    gfp_port i_port (
      .clk(clk), .rst_n(rst_n), .dir_wr(dir_wr[p]), .set_wr(set_wr[p]),
      .wr_mask(wr_mask), .wdata(bus_wdata), .func(pin_func[p*PORT_W +: PORT_W]),
      .dir_q(dir_all[p]), .latch_q(latch_all[p]), .oe(oe_p)
    );
    assign pin_out[p*PORT_W +: PORT_W] = latch_all[p];
    assign pin_oe[p*PORT_W +: PORT_W]  = oe_p;
  end

  assign rd_mapped = (|rd_bank) && (rd_sel != SEL_NONE);

  always_comb begin
    bus_rdata = '0;
    for (int p = 0; p < NUM_PORTS; p++) begin
      if (rd_bank[p]) begin
        if (rd_sel == SEL_DIR)      bus_rdata = dir_all[p];
        else if (rd_sel == SEL_SET) bus_rdata = latch_all[p];
      end
    end
  end

  // R10: unmapped reads return zero
  assert_unmapped_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_mapped |-> (bus_rdata == '0));
endmodule

// File: tb/test_gfp_top.sv
module test_gfp_top;
  localparam int CLK_P = 10;
  localparam int NP    = 5;
  localparam int AW    = 8;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           bus_wr = 1'b0;
  logic [AW-1:0]  bus_addr = '0;
  logic [1:0]     bus_size = '0;
  logic [3:0]     bus_be = '0;
  logic [31:0]    bus_wdata = '0;
  logic [31:0]    bus_rdata;
  logic [NP*32-1:0] pin_func = '0;
  logic [NP*32-1:0] pin_out;
  logic [NP*32-1:0] pin_oe;

  int n_chk = 0;
  int n_bad = 0;
  logic [31:0] m_dir [NP];
  logic [31:0] m_lat [NP];

  always #(CLK_P/2) clk = ~clk;

  gfp_top #(.NUM_PORTS(NP), .ADDR_W(AW)) i_gfp_top (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_size(bus_size), .bus_be(bus_be), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .pin_func(pin_func), .pin_out(pin_out), .pin_oe(pin_oe)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Bit mask written by an access, derived byte by byte from the rules.
  function automatic logic [31:0] ref_mask(input logic [7:0] a, input logic [1:0] sz,
                                           input logic [3:0] be);
    logic [31:0] m = '0;
    for (int k = 0; k < 4; k++) begin
      bit hit;
      hit = (sz == 2'd0 && a[1:0] == k[1:0]) ||
            (sz == 2'd1 && !a[0] && (k / 2) == int'(a[1])) ||
            (sz == 2'd2 && a[1:0] == 2'b00);
      if (hit && be[k]) m[8*k +: 8] = 8'hFF;
    end
    return m;
  endfunction

  function automatic logic [31:0] ref_read(input logic [7:0] a);
    int b = int'(a[7:5]);
    if (b >= NP) return '0;
    if (a[4:2] == 3'd0) return m_dir[b];
    if (a[4:2] == 3'd6) return m_lat[b];
    return '0;
  endfunction

  task automatic wr(input logic [7:0] a, input logic [1:0] sz, input logic [3:0] be,
                    input logic [31:0] d);
    logic [31:0] m;
    int b;
    @(negedge clk);
    bus_addr = a; bus_size = sz; bus_be = be; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
    m = ref_mask(a, sz, be);
    b = int'(a[7:5]);
    if (b < NP && m != 0) begin
      if (a[4:2] == 3'd0) m_dir[b] = (m_dir[b] & ~m) | (d & m);
      else if (a[4:2] == 3'd6)
        m_lat[b] = m_lat[b] | (d & m & m_dir[b] & ~pin_func[b*32 +: 32]);
    end
  endtask

  task automatic rd_chk(input string req, input logic [7:0] a);
    bus_addr = a;
    #1;
    chk(req, bus_rdata, ref_read(a));
  endtask

  task automatic pin_chk(input int p);
    chk("R8 pin_out", pin_out[p*32 +: 32], m_lat[p]);
    chk("R9 pin_oe", pin_oe[p*32 +: 32], m_dir[p] & ~pin_func[p*32 +: 32]);
  endtask

  initial begin
    #(CLK_P * 150000);
    n_bad++;
    n_chk++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    logic [7:0] a;
    for (int p = 0; p < NP; p++) begin m_dir[p] = '0; m_lat[p] = '0; end
    void'($urandom(32'h5EED_1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    for (int p = 0; p < NP; p++) begin
      rd_chk("R1 dir reset", 8'(p * 32));
      rd_chk("R1 set reset", 8'(p * 32 + 8'h18));
      pin_chk(p);
    end
    // R5 full word write
    wr(8'h00, 2'd2, 4'hF, 32'hA5C3_0F81);
    rd_chk("R5 word dir", 8'h00);
    // R3 each byte alias of port 1
    wr(8'h20, 2'd2, 4'hF, 32'h0000_0000);
    for (int k = 0; k < 4; k++) begin
      wr(8'(8'h20 + k), 2'd0, 4'hF, 32'h1111_1111 * (k + 3));
      rd_chk("R3 byte alias", 8'h20);
    end
    // R4 half-word views and misaligned refusals
    wr(8'h42, 2'd1, 4'hF, 32'hBEEF_0000);
    rd_chk("R4 upper half", 8'h40);
    wr(8'h40, 2'd1, 4'hF, 32'h0000_1234);
    rd_chk("R4 lower half", 8'h40);
    wr(8'h41, 2'd1, 4'hF, 32'hFFFF_FFFF);
    rd_chk("R4 odd half ignored", 8'h40);
    wr(8'h42, 2'd2, 4'hF, 32'h0);
    rd_chk("R4 misaligned word ignored", 8'h40);
    // R6 byte enables and reserved size
    wr(8'h60, 2'd2, 4'b0101, 32'hFFFF_FFFF);
    rd_chk("R6 be partial", 8'h60);
    wr(8'h60, 2'd3, 4'hF, 32'h0);
    rd_chk("R6 reserved size", 8'h60);
    // R7 set filtering: port 0 dir = A5C30F81, function mask on low byte
    pin_func[31:0] = 32'h0000_00FF;
    wr(8'h18, 2'd2, 4'hF, 32'hFFFF_FFFF);
    rd_chk("R7 set filtered", 8'h18);
    pin_chk(0);
    wr(8'h18, 2'd2, 4'hF, 32'h0);
    rd_chk("R7 zero no clear", 8'h18);
    // R10 unmapped bank and offset
    wr(8'hA0, 2'd2, 4'hF, 32'hFFFF_FFFF);
    rd_chk("R10 bank5 read", 8'hA0);
    wr(8'h84, 2'd2, 4'hF, 32'hFFFF_FFFF);
    rd_chk("R10 off04 read", 8'h84);
    rd_chk("R10 port4 dir", 8'h80);
    pin_chk(4);
    // R2 random mix against the model
    for (int i = 0; i < 400; i++) begin
      int b;
      int sel;
      b = int'($urandom_range(0, 5));
      sel = int'($urandom_range(0, 9));
      if (sel < 5)      a = 8'(b * 32 + int'($urandom_range(0, 3)));
      else if (sel < 9) a = 8'(b * 32 + 8'h18 + int'($urandom_range(0, 3)));
      else              a = 8'(b * 32 + int'($urandom_range(0, 31)));
      if ($urandom_range(0, 7) == 0 && b < NP) pin_func[b*32 +: 32] = $urandom;
      wr(a, 2'($urandom_range(0, 3)), 4'($urandom), $urandom);
      rd_chk("R2 rand dir", 8'(b * 32));
      rd_chk("R8 rand set", 8'(b * 32 + 8'h18));
      if (b < NP) pin_chk(b);
    end
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule